// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block connects a synchronous request port to an asynchronous static RAM of 131,072 sixteen-bit words. The RAM has active-low chip select, write strobe, read strobe and one select per byte half. A client issues one request at a time. Each request carries a read/write flag, a 17-bit word address, 16 bits of write data and a 2-bit lane mask. The block returns read data together with a one-cycle completion pulse.

Each phase of an access runs for a whole number of clock cycles. That number comes from a nanosecond minimum and the clock-period parameter: the ceiling of the quotient, and never less than one cycle. A write is controlled by the write strobe, and the read strobe stays inactive for the whole write. This lets the controller drive the data bus from the first cycle of the strobe pulse without contending with the RAM's output drivers. A read holds the address and strobes for the access time. It captures the data on the closing edge and then leaves one quiet cycle for the RAM's outputs to turn off before it reports completion. The data bus is split into an output word, an input word and a single drive-enable.

With the default 10 ns clock, the phases are: write pulse 4 cycles, write recovery 2 cycles, read access 6 cycles.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, all five memory strobes are high, the drive-enable is low, `req_ready` is 1, `rsp_done` is 0 and `rsp_rdata` is 0.
- R2: A write with a nonzero mask holds chip select and write strobe low together for exactly WP cycles, where WP is the larger of ceil(40/P) and ceil(25/P) and P is the clock period in ns. The read strobe stays high for the whole write.
- R3: The drive-enable is high only while both chip select and write strobe are low. It falls in the same cycle that the write strobe rises.
- R4: After the acceptance edge of a write with a nonzero mask, `rsp_done` rises after max(ceil(55/P), WP+1) clock edges.
- R5: Mask bit 0 selects data bits 7:0 through the lower-lane select. Mask bit 1 selects bits 15:8 through the upper-lane select. The select of an unmasked lane stays high throughout the access, so that half of the word is not written.
- R6: A read holds chip select and read strobe low, with the write strobe high, for RD cycles, where RD is the larger of ceil(55/P) and ceil(25/P). The data is captured on the edge that ends this interval. Unselected lanes of `rsp_rdata` read as zero.
- R7: After a read capture, one cycle passes with all strobes high before `rsp_done` is high, so done rises RD+1 edges after acceptance.
- R8: A request with mask 00 raises `rsp_done` in the cycle right after acceptance and activates no memory strobe.
- R9: `req_ready` is high only while idle. `rsp_done` is a single-cycle pulse.
- R10: `mem_addr` does not change while chip select is low.
- R11: `rsp_rdata` keeps its value until the next read capture. Write requests leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_rdata | output | 16 | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 17 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM read strobe, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_dq_out | output | 16 | Data driven toward the RAM |
| mem_dq_in | input | 16 | Data returned by the RAM |
| mem_dq_oe | output | 1 | Drive-enable for `mem_dq_out` |

## Verification
The assertions assume that the client offers a request only when `req_ready` is high. They also assume that the request fields are stable on the acceptance edge and that reset is applied before the first request. The stimulus meets these assumptions because each request is raised at a falling edge, only after `req_ready` has been seen high, and dropped right after the accepting rising edge.

The RAM model drives read data only once the read strobes have been low for the full access count, and it drives a garbage pattern on lanes that are not selected. A capture that comes early, or a lane that is not masked to zero, therefore shows up in the returned word. Addresses are drawn from a small pool so that reads often hit words written earlier with partial masks.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_WPULSE,
      PH_WREC,
      PH_RACC,
      PH_RTURN,
      PH_DONE
   } phase_t;

   function automatic int ns_to_cycles(input int ns, input int period);
      int c;
      c = (ns + period - 1) / period;
      if (c < 1) c = 1;
      return c;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             last
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign last = (cnt_q == {{(CNT_W-1){1'b0}}, 1'b1});

   a_r2_timer_loaded_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (load_val != '0));
endmodule

// File: rtl/sram_byte_lanes.sv
module sram_byte_lanes #(
   parameter int LANES  = 2,
   parameter int LANE_W = 8,
   localparam int DW = LANES * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             capture,
   input  logic [LANES-1:0] mask,
   input  logic [DW-1:0]    rd_in,
   output logic [LANES-1:0] lane_sel_n,
   output logic [DW-1:0]    rd_data
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_sel_n[i] = !(active && mask[i]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rd_data[i*LANE_W +: LANE_W] <= '0;
         else if (capture)
            rd_data[i*LANE_W +: LANE_W] <= mask[i] ? rd_in[i*LANE_W +: LANE_W] : '0;
      end

      a_r5_lane_off_when_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
         !mask[i] |-> lane_sel_n[i]);
   end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W        = 17,
   parameter int LANES         = 2,
   parameter int LANE_W        = 8,
   parameter int CLK_PERIOD_NS = 10,
   parameter int T_ADDR_ACC_NS = 55,
   parameter int T_OE_ACC_NS   = 25,
   parameter int T_WCYCLE_NS   = 55,
   parameter int T_WPULSE_NS   = 40,
   parameter int T_DSETUP_NS   = 25
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_write,
   input  logic [ADDR_W-1:0]         req_addr,
   input  logic [LANES*LANE_W-1:0]   req_wdata,
   input  logic [LANES-1:0]          req_mask,
   output logic [LANES*LANE_W-1:0]   rsp_rdata,
   output logic                      rsp_done,
   output logic [ADDR_W-1:0]         mem_addr,
   output logic                      mem_ce_n,
   output logic                      mem_we_n,
   output logic                      mem_oe_n,
   output logic                      mem_lb_n,
   output logic                      mem_ub_n,
   output logic [LANES*LANE_W-1:0]   mem_dq_out,
   input  logic [LANES*LANE_W-1:0]   mem_dq_in,
   output logic                      mem_dq_oe
);
   localparam int DW     = LANES * LANE_W;
   localparam int WP_CYC = max_int(ns_to_cycles(T_WPULSE_NS, CLK_PERIOD_NS),
                                   ns_to_cycles(T_DSETUP_NS, CLK_PERIOD_NS));
   localparam int WC_CYC = ns_to_cycles(T_WCYCLE_NS, CLK_PERIOD_NS);
   localparam int WR_CYC = (WC_CYC > WP_CYC) ? (WC_CYC - WP_CYC) : 1;
   localparam int RD_CYC = max_int(ns_to_cycles(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                   ns_to_cycles(T_OE_ACC_NS, CLK_PERIOD_NS));
   localparam int MAX_CYC = max_int(max_int(WP_CYC, WR_CYC), RD_CYC);
   localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

   if (LANES != 2)      begin : g_bad_lanes  $error("two byte lanes required"); end
   if (LANE_W < 1)      begin : g_bad_lanew  $error("lane width must be positive"); end
   if (CLK_PERIOD_NS < 1) begin : g_bad_clk  $error("clock period must be positive"); end

   phase_t           st_q, st_d;
   logic             t_load, t_last;
   logic [CNT_W-1:0] t_val;
   logic [DW-1:0]    wdata_q;
   logic [LANES-1:0] mask_q, lane_sel_n;
   logic             accept, strobe_on, capture;

   assign accept = (st_q == PH_IDLE) && req_valid;

   always_comb begin
      st_d   = st_q;
      t_load = 1'b0;
      t_val  = '0;
      unique case (st_q)
         PH_IDLE: if (req_valid) begin
            if (req_mask == '0) st_d = PH_DONE;
            else if (req_write) begin
               st_d = PH_WPULSE; t_load = 1'b1; t_val = CNT_W'(WP_CYC);
            end else begin
               st_d = PH_RACC;   t_load = 1'b1; t_val = CNT_W'(RD_CYC);
            end
         end
         PH_WPULSE: if (t_last) begin
            st_d = PH_WREC; t_load = 1'b1; t_val = CNT_W'(WR_CYC);
         end
         PH_WREC:   if (t_last) st_d = PH_DONE;
         PH_RACC:   if (t_last) st_d = PH_RTURN;
         PH_RTURN:  st_d = PH_DONE;
         PH_DONE:   st_d = PH_IDLE;
         default:   st_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= PH_IDLE;
         mem_addr <= '0;
         wdata_q  <= '0;
         mask_q   <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            mem_addr <= req_addr;
            wdata_q  <= req_wdata;
            mask_q   <= req_mask;
         end
      end
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .last(t_last)
   );

   assign strobe_on = (st_q == PH_WPULSE) || (st_q == PH_RACC);
   assign capture   = (st_q == PH_RACC) && t_last;

   sram_byte_lanes #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
      .clk(clk), .rst_n(rst_n), .active(strobe_on), .capture(capture),
      .mask(mask_q), .rd_in(mem_dq_in), .lane_sel_n(lane_sel_n), .rd_data(rsp_rdata)
   );

   assign mem_ce_n   = !strobe_on;
   assign mem_we_n   = (st_q != PH_WPULSE);
   assign mem_oe_n   = (st_q != PH_RACC);
   assign mem_dq_oe  = (st_q == PH_WPULSE);
   assign mem_dq_out = wdata_q;
   assign mem_lb_n   = lane_sel_n[0];
   assign mem_ub_n   = lane_sel_n[1];
   assign req_ready  = (st_q == PH_IDLE);
   assign rsp_done   = (st_q == PH_DONE);

   // Write-pulse width check with a counter
   logic [CNT_W-1:0] we_low_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         we_low_cnt <= '0;
      else if (!mem_we_n) we_low_cnt <= we_low_cnt + 1'b1;
      else                we_low_cnt <= '0;
   end

   a_r2_we_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_n && $past(!mem_we_n)) |-> ($past(we_low_cnt) == CNT_W'(WP_CYC - 1)));
   a_r2_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);
   a_r3_drive_inside_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && !mem_ce_n));
   a_r3_drive_off_with_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_dq_oe);
   a_r8_zero_mask_fast: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_mask == '0) |=> (rsp_done && mem_ce_n));
   a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_ready);
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);
   a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));
   a_r11_rdata_held_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |=> $stable(rsp_rdata));
endmodule

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
   localparam int P  = 10;
   localparam int WP = ((40 + P - 1) / P > (25 + P - 1) / P) ? (40 + P - 1) / P : (25 + P - 1) / P;
   localparam int WC = (55 + P - 1) / P;
   localparam int RD = ((55 + P - 1) / P > (25 + P - 1) / P) ? (55 + P - 1) / P : (25 + P - 1) / P;
   localparam int W_EDGES = (WC > WP) ? WC : WP + 1;
   localparam logic [15:0] JUNK = 16'hA5C3;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0;
   logic [16:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic req_ready, rsp_done;
   logic [15:0] rsp_rdata, mem_dq_out;
   logic [15:0] mem_dq_in = JUNK;
   logic [16:0] mem_addr;
   logic mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe;

   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   sram_lane_ctrl uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_mask(req_mask), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
      .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
   );

   // RAM model and reference memory
   logic [15:0] ram [int];
   logic [15:0] ref_mem [int];
   int rd_age = 0;

   function automatic logic [15:0] init_word(input logic [16:0] a);
      return a[15:0] ^ 16'h3C96;
   endfunction

   function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                         input logic [1:0] m);
      return {m[1] ? nw[15:8] : old[15:8], m[0] ? nw[7:0] : old[7:0]};
   endfunction

   function automatic logic [15:0] ram_rd(input logic [16:0] a);
      return ram.exists(int'(a)) ? ram[int'(a)] : init_word(a);
   endfunction

   function automatic logic [15:0] ref_rd(input logic [16:0] a);
      return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
   endfunction

   always @(posedge clk) begin
      if (!mem_ce_n && !mem_we_n && mem_dq_oe)
         ram[int'(mem_addr)] = merge(ram_rd(mem_addr), mem_dq_out, {!mem_ub_n, !mem_lb_n});
      if (!mem_ce_n && !mem_oe_n) rd_age = rd_age + 1;
      else rd_age = 0;
   end

   always @(negedge clk) begin
      logic [15:0] w;
      w = ram_rd(mem_addr);
      mem_dq_in = JUNK;
      if (!mem_ce_n && !mem_oe_n && mem_we_n && rd_age >= RD - 1) begin
         if (!mem_lb_n) mem_dq_in[7:0]  = w[7:0];
         if (!mem_ub_n) mem_dq_in[15:8] = w[15:8];
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xfer(input bit wr, input logic [16:0] a, input logic [15:0] d,
                       input logic [1:0] m);
      int edges = 0, we_low = 0;
      bit lane_bad = 0, oe_bad = 0, dq_bad = 0, strobe_seen = 0, addr_bad = 0;
      bit turn_ok = 0;
      logic [15:0] prev_rd, exp;
      @(negedge clk);
      check(req_ready == 1'b1, "R9 ready when idle", req_ready, 1);
      prev_rd = rsp_rdata;
      req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
      @(posedge clk);
      #1 req_valid = 0;
      forever begin
         @(negedge clk);
         if (rsp_done || edges > 200) break;
         if (!mem_ce_n) begin
            strobe_seen = 1;
            if (mem_lb_n != !m[0] || mem_ub_n != !m[1]) lane_bad = 1;
            if (mem_addr != a) addr_bad = 1;
         end
         if (!mem_we_n) begin
            we_low++;
            if (!mem_oe_n) oe_bad = 1;
         end
         if (mem_dq_oe && (mem_we_n || mem_ce_n)) dq_bad = 1;
         if (!mem_we_n && !mem_dq_oe) dq_bad = 1;
         if (req_ready) dq_bad = 1;
         if (!wr && edges == RD)
            turn_ok = mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n;
         @(posedge clk);
         edges++;
      end
      if (edges > 200) begin
         check(0, "watchdog", edges, 0);
         return;
      end
      check(!lane_bad, "R5 lane selects follow mask", m, m);
      check(!addr_bad, "R10 address held", 0, 0);
      check(!dq_bad, "R3 drive only inside write pulse", 0, 0);
      if (m == 2'b00) begin
         check(edges == 0, "R8 zero-mask done timing", edges, 0);
         check(!strobe_seen, "R8 zero-mask no strobe", strobe_seen, 0);
         check(rsp_rdata == prev_rd, "R11 rdata held", rsp_rdata, prev_rd);
      end else if (wr) begin
         ref_mem[int'(a)] = merge(ref_rd(a), d, m);
         check(we_low == WP, "R2 write pulse width", we_low, WP);
         check(!oe_bad, "R2 read strobe high in write", 0, 0);
         check(edges == W_EDGES, "R4 write done timing", edges, W_EDGES);
         check(rsp_rdata == prev_rd, "R11 rdata held over write", rsp_rdata, prev_rd);
      end else begin
         exp = ref_rd(a);
         exp = {m[1] ? exp[15:8] : 8'h00, m[0] ? exp[7:0] : 8'h00};
         check(rsp_rdata == exp, "R6 read data", rsp_rdata, exp);
         check(edges == RD + 1, "R7 read done timing", edges, RD + 1);
         check(turn_ok, "R7 quiet turn cycle", turn_ok, 1);
      end
      @(negedge clk);
      check(!rsp_done, "R9 done single pulse", rsp_done, 0);
   endtask

   initial begin
      process wd;
      fork
         begin
            repeat (100000) @(posedge clk);
            check(0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
         end
      join_none
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      check(mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
            "R1 reset strobes", {mem_ce_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, mem_dq_oe}, 6'b111110);
      check(req_ready && !rsp_done && rsp_rdata == 0, "R1 reset handshake",
            {req_ready, rsp_done, rsp_rdata}, 18'h20000);
      rst_n = 1;
      // directed corners
      xfer(1, 17'h00010, 16'h1234, 2'b11);
      xfer(0, 17'h00010, 16'h0000, 2'b11);
      xfer(1, 17'h00010, 16'hABCD, 2'b01);   // R5 lower only
      xfer(0, 17'h00010, 16'h0000, 2'b11);
      xfer(1, 17'h00010, 16'h9F00, 2'b10);   // R5 upper only
      xfer(0, 17'h00010, 16'h0000, 2'b11);
      xfer(0, 17'h00010, 16'h0000, 2'b01);   // R6 upper lane reads zero
      xfer(0, 17'h00010, 16'h0000, 2'b10);
      xfer(1, 17'h00010, 16'hFFFF, 2'b00);   // R8 write with no lanes
      xfer(0, 17'h00010, 16'h0000, 2'b11);
      xfer(0, 17'h00010, 16'h0000, 2'b00);   // R8 read with no lanes
      xfer(1, 17'h1FFFF, 16'h5AA5, 2'b11);
      xfer(0, 17'h1FFFF, 16'h0000, 2'b11);
      xfer(0, 17'h00000, 16'h0000, 2'b11);
      // constrained random
      for (int i = 0; i < 150; i++) begin
         logic [16:0] a;
         a = {($urandom % 4 == 0) ? 2'b11 : 2'b00, 9'h000, 6'($urandom % 16)};
         xfer(1'($urandom % 2), a, 16'($urandom), 2'($urandom));
      end
      wd = null;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule